// File: doc/BRIEF.md
# Load-Store Byte-Lane Alignment Unit

This unit sits between a 32-bit integer pipeline and a word-wide data memory. For every memory operation it receives an opcode, a base register value, a signed 16-bit displacement, store data and a destination register index. It forms the effective address and rejects accesses whose alignment does not suit their size. For stores it produces byte enables with the store data steered onto the matching lanes. For loads it picks the addressed byte or halfword out of the returned word and sign- or zero-extends it before it reaches the register writeback port.

Memory is big-endian: byte offset 0 of a word sits in bits 31:24 and is enabled by byte-enable bit 3. A 64-bit load is run as two memory beats. The lower-addressed word goes to the destination register and the next word goes to the register one index higher. The unit raises a stall output during the extra beat. Every output is registered. The memory is assumed to return read data on the edge that follows a request, which suits an inferred synchronous RAM.

Top module: `lsu_lane_align`

## Requirements
- R1: The effective address is req_base plus req_offset sign-extended to 32 bits. Every memory request presents that address with bits 1:0 forced to zero on mem_addr.
- R2: Byte loads return the byte at the effective address. Byte offset 0 is bits 31:24 of mem_rdata and offset 3 is bits 7:0. Opcode 0 copies bit 7 of the byte into bits 31:8, and opcode 1 fills bits 31:8 with zeros.
- R3: Halfword loads return the halfword at the effective address. Offset 0 is bits 31:16 and offset 2 is bits 15:0. Opcode 2 copies bit 15 into bits 31:16, and opcode 3 fills them with zeros.
- R4: The word load (opcode 4) writes the whole memory word unchanged.
- R5: An access is misaligned when it is a halfword access at an odd address, a word access at an address whose bits 1:0 are not zero, or a 64-bit load at an address whose bits 2:0 are not zero. A misaligned access sets addr_err for one cycle and issues no memory request and no register writeback.
- R6: Stores write only the addressed bytes. Opcode 6 stores the low byte of req_wdata and enables the single bit 3 minus the byte offset. Opcode 7 stores bits 15:0 and enables 4'b1100 at offset 0 or 4'b0011 at offset 2. Opcode 8 stores the whole word with enables 4'b1111.
- R7: The 64-bit load (opcode 5) issues two read requests on consecutive cycles, at the effective address and then at that address plus 4. The first word is written back to req_rd and the second to req_rd+1, on consecutive cycles. stall is high for exactly the cycle between the two requests. A request presented while stall is high is ignored.
- R8: A 64-bit load whose req_rd is 31 sets addr_err and causes no memory request and no writeback.
- R9: A load whose destination is register 0 produces no writeback pulse.
- R10: A request accepted at clock edge N drives mem_req after edge N. Its load writeback (wb_en) appears after edge N+2. While rst is high, all strobes (mem_req, mem_we, wb_en, stall, addr_err) are low.
- R11: Opcodes 9 to 15 cause no memory request, no writeback and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 4 | Operation code (see requirements) |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store source register value |
| req_rd | input | 5 | Load destination register index |
| stall | output | 1 | Extra beat of a 64-bit load in progress; new requests ignored |
| addr_err | output | 1 | Alignment or register-pair fault, one-cycle pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte enables, bit 3 = lowest byte address |
| mem_wdata | output | 32 | Lane-steered store data |
| mem_rdata | input | 32 | Read data, valid the cycle after the request |
| wb_en | output | 1 | Register writeback strobe |
| wb_idx | output | 5 | Writeback register index |
| wb_data | output | 32 | Extended load value |

## Verification
The bench builds the unit with its defaults: a 32-bit data path, a 16-bit displacement and a 5-bit register index. The 16-bit displacement lets a vector of 0xFFF0 check that negative offsets subtract from the base. The 5-bit index puts register 31 within reach, so the register-pair fault can be tested, and register 0 covers writeback suppression. Four byte lanes mean that every byte offset and both halfword positions appear in the load and store vectors. The read-after-store vectors then show that bytes outside the enables keep their values.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [3:0] {
    OP_LDB_S = 4'd0,
    OP_LDB_U = 4'd1,
    OP_LDH_S = 4'd2,
    OP_LDH_U = 4'd3,
    OP_LDW   = 4'd4,
    OP_LDD   = 4'd5,
    OP_STB   = 4'd6,
    OP_STH   = 4'd7,
    OP_STW   = 4'd8
  } lsu_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16
) (
  input  logic [XLEN-1:0]  base,
  input  logic [OFF_W-1:0] offset,
  input  acc_size_e        size,
  output logic [XLEN-1:0]  ea,
  output logic             misaligned
);
  localparam int EXT_W = XLEN - OFF_W;

  always_comb begin
    ea = base + {{EXT_W{offset[OFF_W-1]}}, offset};
    unique case (size)
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = ea[0];
      SZ_WORD: misaligned = |ea[1:0];
      default: misaligned = |ea[2:0];
    endcase
  end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  acc_size_e                      size,
  input  logic [$clog2(XLEN/8)-1:0]      lane,
  input  logic [XLEN-1:0]                src,
  output logic [XLEN/8-1:0]              be,
  output logic [XLEN-1:0]                data
);
  localparam int NL = XLEN / 8;
  localparam int LW = $clog2(NL);

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic       lane_en;
    logic [7:0] lane_byte;

    always_comb begin
      unique case (size)
        SZ_BYTE: begin
          lane_en   = (lane == LW'(l));
          lane_byte = src[7:0];
        end
        SZ_HALF: begin
          lane_en   = ((lane >> 1) == LW'(l / 2));
          lane_byte = ((l % 2) == 0) ? src[15:8] : src[7:0];
        end
        default: begin
          lane_en   = 1'b1;
          lane_byte = src[XLEN-1-8*l -: 8];
        end
      endcase
    end

    assign be[NL-1-l]            = lane_en;
    assign data[XLEN-1-8*l -: 8] = lane_byte;
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]             rdata,
  input  acc_size_e                   size,
  input  logic [$clog2(XLEN/8)-1:0]   lane,
  input  logic                        sx,
  output logic [XLEN-1:0]             value
);
  localparam int NL = XLEN / 8;
  localparam int LW = $clog2(NL);

  logic [XLEN-1:0] bshift, hshift;
  logic [7:0]      sel_b;
  logic [15:0]     sel_h;
  logic [LW-1:0]   hlane;
  int              bsh, hsh;

  always_comb begin
    hlane  = {lane[LW-1:1], 1'b0};
    bsh    = 8 * (NL - 1 - int'(lane));
    hsh    = 8 * (NL - 2 - int'(hlane));
    bshift = rdata >> bsh;
    hshift = rdata >> hsh;
    sel_b  = bshift[7:0];
    sel_h  = hshift[15:0];
    unique case (size)
      SZ_BYTE: value = {{(XLEN-8){sx & sel_b[7]}}, sel_b};
      SZ_HALF: value = {{(XLEN-16){sx & sel_h[15]}}, sel_h};
      default: value = rdata;
    endcase
  end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int OFF_W  = 16,
  parameter int RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [3:0]        req_op,
  input  logic [XLEN-1:0]   req_base,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [XLEN-1:0]   req_wdata,
  input  logic [RIDX_W-1:0] req_rd,
  output logic              stall,
  output logic              addr_err,
  output logic              mem_req,
  output logic              mem_we,
  output logic [XLEN-1:0]   mem_addr,
  output logic [XLEN/8-1:0] mem_be,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic              wb_en,
  output logic [RIDX_W-1:0] wb_idx,
  output logic [XLEN-1:0]   wb_data
);
  localparam int NL = XLEN / 8;
  localparam int LW = $clog2(NL);

  // request decode
  logic      op_ok, is_st, is_dw, sgn;
  acc_size_e sz;

  always_comb begin
    op_ok = 1'b1;
    is_st = 1'b0;
    is_dw = 1'b0;
    sgn   = 1'b0;
    sz    = SZ_WORD;
    case (req_op)
      OP_LDB_S: begin sz = SZ_BYTE; sgn = 1'b1; end
      OP_LDB_U: sz = SZ_BYTE;
      OP_LDH_S: begin sz = SZ_HALF; sgn = 1'b1; end
      OP_LDH_U: sz = SZ_HALF;
      OP_LDW:   sz = SZ_WORD;
      OP_LDD:   begin sz = SZ_DBL; is_dw = 1'b1; end
      OP_STB:   begin sz = SZ_BYTE; is_st = 1'b1; end
      OP_STH:   begin sz = SZ_HALF; is_st = 1'b1; end
      OP_STW:   begin sz = SZ_WORD; is_st = 1'b1; end
      default:  op_ok = 1'b0;
    endcase
  end

  logic [XLEN-1:0] ea;
  logic            misaligned;

  lsu_agen #(.XLEN(XLEN), .OFF_W(OFF_W)) u_agen (
    .base       (req_base),
    .offset     (req_offset),
    .size       (sz),
    .ea         (ea),
    .misaligned (misaligned)
  );

  logic [NL-1:0]   st_be;
  logic [XLEN-1:0] st_data;

  lsu_store_steer #(.XLEN(XLEN)) u_steer (
    .size (sz),
    .lane (ea[LW-1:0]),
    .src  (req_wdata),
    .be   (st_be),
    .data (st_data)
  );

  // issue-stage and response-stage load tags
  logic              dw_pend;
  logic              iss_v, rsp_v;
  acc_size_e         iss_sz, rsp_sz;
  logic              iss_sx, rsp_sx;
  logic [LW-1:0]     iss_lane, rsp_lane;
  logic [RIDX_W-1:0] iss_rd, rsp_rd;
  logic [XLEN-1:0]   ld_val;

  lsu_load_extract #(.XLEN(XLEN)) u_extract (
    .rdata (mem_rdata),
    .size  (rsp_sz),
    .lane  (rsp_lane),
    .sx    (rsp_sx),
    .value (ld_val)
  );

  logic accept, pair_bad;
  assign accept   = req_valid && !dw_pend && op_ok;
  assign pair_bad = is_dw && (req_rd == {RIDX_W{1'b1}});
  assign stall    = dw_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      dw_pend   <= 1'b0;
      addr_err  <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      iss_v     <= 1'b0;
      iss_sz    <= SZ_WORD;
      iss_sx    <= 1'b0;
      iss_lane  <= '0;
      iss_rd    <= '0;
      rsp_v     <= 1'b0;
      rsp_sz    <= SZ_WORD;
      rsp_sx    <= 1'b0;
      rsp_lane  <= '0;
      rsp_rd    <= '0;
      wb_en     <= 1'b0;
      wb_idx    <= '0;
      wb_data   <= '0;
    end else begin
      mem_req  <= 1'b0;
      mem_we   <= 1'b0;
      addr_err <= 1'b0;
      iss_v    <= 1'b0;

      rsp_v    <= iss_v;
      rsp_sz   <= iss_sz;
      rsp_sx   <= iss_sx;
      rsp_lane <= iss_lane;
      rsp_rd   <= iss_rd;

      wb_en    <= rsp_v && (rsp_rd != '0);
      wb_idx   <= rsp_rd;
      wb_data  <= ld_val;

      if (dw_pend) begin
        dw_pend  <= 1'b0;
        mem_req  <= 1'b1;
        mem_addr <= mem_addr + XLEN'(NL);
        mem_be   <= '1;
        iss_v    <= 1'b1;
        iss_sz   <= SZ_WORD;
        iss_sx   <= 1'b0;
        iss_lane <= '0;
        iss_rd   <= iss_rd + RIDX_W'(1);
      end else if (accept) begin
        if (misaligned || pair_bad) begin
          addr_err <= 1'b1;
        end else begin
          mem_req   <= 1'b1;
          mem_we    <= is_st;
          mem_addr  <= {ea[XLEN-1:LW], {LW{1'b0}}};
          mem_be    <= is_st ? st_be : '1;
          mem_wdata <= st_data;
          iss_v     <= !is_st;
          iss_sz    <= is_dw ? SZ_WORD : sz;
          iss_sx    <= sgn;
          iss_lane  <= ea[LW-1:0];
          iss_rd    <= req_rd;
          dw_pend   <= is_dw;
        end
      end
    end
  end

  // a fault never coincides with a memory access or a pending second beat
  assert_err_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    addr_err |-> (!mem_req && !stall));

  // store enables cover one byte, one halfword pair or the full word
  assert_store_be_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2
                             || $countones(mem_be) == NL));

  // the extra beat lasts exactly one cycle
  assert_one_extra_beat_R7: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall);

  // the second beat reads the next word
  assert_second_beat_R7: assert property (@(posedge clk) disable iff (rst)
    stall |=> (mem_req && !mem_we && mem_addr == $past(mem_addr) + XLEN'(NL)));

  // stall only follows a read request
  assert_stall_after_read_R7: assert property (@(posedge clk) disable iff (rst)
    stall |-> (mem_req && !mem_we));

  // register 0 is never written
  assert_no_zero_wb_R9: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (wb_idx != '0));

endmodule

// File: tb/lsu_lane_align_bench.sv
module lsu_lane_align_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, req_valid;
  logic [3:0]  req_op;
  logic [31:0] req_base, req_wdata;
  logic [15:0] req_offset;
  logic [4:0]  req_rd;
  logic        stall, addr_err, mem_req, mem_we, wb_en;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, wb_data;
  logic [3:0]  mem_be;
  logic [4:0]  wb_idx;

  lsu_lane_align u_lsu_lane_align (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
    .req_rd(req_rd), .stall(stall), .addr_err(addr_err), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  // synchronous memory model, big-endian lanes
  logic [31:0] mem [64];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) mem[i] <= 32'h0;
      mem[4]    <= 32'h8196A5F0;
      mem[5]    <= 32'h13572468;
      mem[8]    <= 32'h11223344;
      mem_rdata <= 32'h0;
    end else if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[7:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[7:2]];
      end
    end
  end

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] base;
    logic [15:0] off;
    logic [31:0] wd;
    logic [4:0]  rd;
    logic        err;
    logic [1:0]  nwb;
    logic [3:0]  be;
    logic [31:0] d0;
    logic [31:0] d1;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{4'd4, 32'h10, 16'h0000, 32'h0,        5'd3,  1'b0, 2'd1, 4'h0, 32'h8196A5F0, 32'h0},
    '{4'd0, 32'h10, 16'h0000, 32'h0,        5'd3,  1'b0, 2'd1, 4'h0, 32'hFFFFFF81, 32'h0},
    '{4'd1, 32'h10, 16'h0001, 32'h0,        5'd3,  1'b0, 2'd1, 4'h0, 32'h00000096, 32'h0},
    '{4'd0, 32'h13, 16'h0000, 32'h0,        5'd3,  1'b0, 2'd1, 4'h0, 32'hFFFFFFF0, 32'h0},
    '{4'd1, 32'h12, 16'h0000, 32'h0,        5'd3,  1'b0, 2'd1, 4'h0, 32'h000000A5, 32'h0},
    '{4'd2, 32'h12, 16'h0000, 32'h0,        5'd3,  1'b0, 2'd1, 4'h0, 32'hFFFFA5F0, 32'h0},
    '{4'd3, 32'h10, 16'h0000, 32'h0,        5'd3,  1'b0, 2'd1, 4'h0, 32'h00008196, 32'h0},
    '{4'd2, 32'h11, 16'h0000, 32'h0,        5'd3,  1'b1, 2'd0, 4'h0, 32'h0,        32'h0},
    '{4'd4, 32'h12, 16'h0000, 32'h0,        5'd3,  1'b1, 2'd0, 4'h0, 32'h0,        32'h0},
    '{4'd4, 32'h20, 16'hFFF0, 32'h0,        5'd7,  1'b0, 2'd1, 4'h0, 32'h8196A5F0, 32'h0},
    '{4'd5, 32'h10, 16'h0000, 32'h0,        5'd4,  1'b0, 2'd2, 4'h0, 32'h8196A5F0, 32'h13572468},
    '{4'd5, 32'h14, 16'h0000, 32'h0,        5'd4,  1'b1, 2'd0, 4'h0, 32'h0,        32'h0},
    '{4'd5, 32'h10, 16'h0000, 32'h0,        5'd31, 1'b1, 2'd0, 4'h0, 32'h0,        32'h0},
    '{4'd4, 32'h10, 16'h0000, 32'h0,        5'd0,  1'b0, 2'd0, 4'h0, 32'h0,        32'h0},
    '{4'd6, 32'h21, 16'h0000, 32'h123456AB, 5'd0,  1'b0, 2'd0, 4'h4, 32'h0,        32'h0},
    '{4'd4, 32'h20, 16'h0000, 32'h0,        5'd8,  1'b0, 2'd1, 4'h0, 32'h11AB3344, 32'h0},
    '{4'd7, 32'h22, 16'h0000, 32'hFFFF7788, 5'd0,  1'b0, 2'd0, 4'h3, 32'h0,        32'h0},
    '{4'd4, 32'h20, 16'h0000, 32'h0,        5'd8,  1'b0, 2'd1, 4'h0, 32'h11AB7788, 32'h0},
    '{4'd8, 32'h30, 16'hFFF0, 32'hDEADBEEF, 5'd0,  1'b0, 2'd0, 4'hF, 32'h0,        32'h0},
    '{4'd4, 32'h20, 16'h0000, 32'h0,        5'd8,  1'b0, 2'd1, 4'h0, 32'hDEADBEEF, 32'h0},
    '{4'd6, 32'h23, 16'h0000, 32'h0000005A, 5'd0,  1'b0, 2'd0, 4'h1, 32'h0,        32'h0},
    '{4'd4, 32'h20, 16'h0000, 32'h0,        5'd8,  1'b0, 2'd1, 4'h0, 32'hDEADBE5A, 32'h0},
    '{4'd7, 32'h21, 16'h0000, 32'h0000CCCC, 5'd0,  1'b1, 2'd0, 4'h0, 32'h0,        32'h0},
    '{4'd4, 32'h20, 16'h0000, 32'h0,        5'd8,  1'b0, 2'd1, 4'h0, 32'hDEADBE5A, 32'h0},
    '{4'd15, 32'h20, 16'h0000, 32'h0,       5'd9,  1'b0, 2'd0, 4'h0, 32'h0,        32'h0}
  };

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input logic ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic string tag_of(vec_t v);
    if (v.op > 4'd8)                  return "R11";
    if (v.op == 4'd5 && v.rd == 5'd31) return "R8";
    if (v.err)                        return "R5";
    if (v.op >= 4'd6)                 return "R6";
    if (v.rd == 5'd0)                 return "R9";
    if (v.op == 4'd5)                 return "R7";
    if (v.op == 4'd4)                 return "R4";
    if (v.op >= 4'd2)                 return "R3";
    return "R2";
  endfunction

  task automatic run(input vec_t v);
    int nreq = 0, nwb = 0, nstall = 0, first_wb = -1, exp_req;
    logic err_seen = 1'b0;
    logic [3:0] be_seen = 4'h0;
    logic [31:0] a_seen = 32'h0, ea;
    logic [31:0] d [2];
    logic [4:0]  ix [2];
    string tg;
    tg = tag_of(v);
    ea = v.base + {{16{v.off[15]}}, v.off};
    exp_req = (v.err || v.op > 4'd8) ? 0 : ((v.op == 4'd5) ? 2 : 1);
    d[0] = 0; d[1] = 0; ix[0] = 0; ix[1] = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = v.op; req_base = v.base; req_offset = v.off;
    req_wdata = v.wd; req_rd = v.rd;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (k == 0) req_valid = 1'b0;
      if (mem_req) begin
        if (nreq == 0) a_seen = mem_addr;
        if (mem_we) be_seen = mem_be;
        nreq++;
      end
      if (addr_err) err_seen = 1'b1;
      if (stall) nstall++;
      if (wb_en) begin
        if (nwb < 2) begin d[nwb] = wb_data; ix[nwb] = wb_idx; end
        if (first_wb < 0) first_wb = k;
        nwb++;
      end
    end
    chk(err_seen == v.err, tg, "addr_err", 32'(err_seen), 32'(v.err));
    chk(nreq == exp_req, tg, "memory request count", nreq, exp_req);
    if (exp_req > 0) chk(a_seen == {ea[31:2], 2'b00}, "R1", "mem_addr", a_seen, {ea[31:2], 2'b00});
    if (v.op >= 4'd6 && v.op <= 4'd8 && !v.err) chk(be_seen == v.be, "R6", "mem_be", 32'(be_seen), 32'(v.be));
    chk(nwb == int'(v.nwb), tg, "writeback count", nwb, 32'(v.nwb));
    if (nwb >= 1 && v.nwb >= 1) begin
      chk(d[0] == v.d0, tg, "wb_data", d[0], v.d0);
      chk(ix[0] == v.rd, tg, "wb_idx", 32'(ix[0]), 32'(v.rd));
      chk(first_wb == 2, "R10", "writeback cycle", first_wb, 2);
    end
    if (nwb == 2 && v.nwb == 2) begin
      chk(d[1] == v.d1, "R7", "second wb_data", d[1], v.d1);
      chk(ix[1] == v.rd + 5'd1, "R7", "second wb_idx", 32'(ix[1]), 32'(v.rd + 5'd1));
    end
    chk(nstall == ((v.op == 4'd5 && !v.err) ? 1 : 0), "R7", "stall cycles", nstall,
        (v.op == 4'd5 && !v.err) ? 1 : 0);
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_op = 4'd0; req_base = 32'h0;
    req_offset = 16'h0; req_wdata = 32'h0; req_rd = 5'd0;
    repeat (3) @(negedge clk);
    // R10: quiet outputs under reset
    chk(!mem_req && !mem_we && !wb_en && !stall && !addr_err, "R10", "reset strobes",
        {27'h0, mem_req, mem_we, wb_en, stall, addr_err}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(!mem_req && !wb_en, "R10", "idle after reset", {30'h0, mem_req, wb_en}, 32'h0);

    for (int i = 0; i < NV; i++) run(VECS[i]);

    // R7: a request offered during the stall cycle is dropped
    begin
      int nwb = 0, nreq = 0;
      logic bad_idx = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_op = 4'd5; req_base = 32'h10; req_offset = 16'h0; req_rd = 5'd6;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (k == 0) begin
          chk(stall, "R7", "stall during second beat", 32'(stall), 32'h1);
          req_op = 4'd4; req_rd = 5'd9;
        end else if (k == 1) req_valid = 1'b0;
        if (mem_req) nreq++;
        if (wb_en) begin
          nwb++;
          if (wb_idx != 5'd6 && wb_idx != 5'd7) bad_idx = 1'b1;
        end
      end
      chk(nreq == 2, "R7", "requests with stalled input", nreq, 2);
      chk(nwb == 2 && !bad_idx, "R7", "writebacks with stalled input", nwb, 2);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule